// File: doc/BRIEF.md
# Floating-Point Register and Compare Unit

This block is the front end of a small single-precision floating-point coprocessor. It holds a bank of 32 floating-point registers of 32 bits each. It moves words between that bank and the integer side of the processor. It evaluates equal, less-or-equal and less-than comparisons between two registers. Each comparison leaves its result in one condition flag, and the block reports that flag so the pipeline can resolve branch-if-true and branch-if-false instructions.

The comparison does not decode the floating-point format. Each 32-bit word is read as a sign-magnitude integer: bit 31 is the sign and bits 30:0 are the magnitude. For ordinary single-precision values this gives the correct floating-point ordering. NaN patterns get no special handling and simply take part in the same integer ordering. Arithmetic and exceptions are outside this unit.

A caller presents an operation code, two register indices and an integer write word on every cycle. The codes are:

| Code | Name | Effect |
|------|------|--------|
| 0 | IDLE | no effect |
| 1 | MOVE_IN | copy the integer write word into a register |
| 2 | MOVE_OUT | read a register onto the integer read bus |
| 3 | CMP_EQ | compare for equal |
| 4 | CMP_LE | compare for less-or-equal |
| 5 | CMP_LT | compare for less-than |
| 6 | BR_TRUE | branch if the flag is set |
| 7 | BR_FALSE | branch if the flag is clear |

The flag register has two states, CLEAR and SET. It moves between them only when a compare code is presented.

Top module: `fpc_unit`

## Requirements
- R1: Reset clears the condition flag to 0 and every floating-point register to 0x00000000.
- R2: On op 1 (MOVE_IN), `wdata_i` is written into register `fs_i` at the rising clock edge, and reading that register in a later cycle returns the value.
- R3: With op 2 (MOVE_OUT), `rdata_o` combinationally shows register `fs_i`. With any other op, `rdata_o` is 0.
- R4: Op 3 (CMP_EQ) sets the flag to 1 at the next edge when registers `fs_i` and `ft_i` hold the same pattern, or when both have a zero magnitude (+0 and -0 are equal). Otherwise it sets the flag to 0.
- R5: Op 5 (CMP_LT) sets the flag to 1 exactly when `fs_i` is less than `ft_i` under sign-magnitude ordering. When both signs are negative, the larger magnitude is the smaller value. When the signs differ, the negative operand is smaller, unless both magnitudes are zero.
- R6: Op 4 (CMP_LE) sets the flag to the logical OR of the less-than result and the equal result for the same pair.
- R7: The flag changes only on ops 3, 4 and 5. Every other op leaves it unchanged.
- R8: `br_taken_o` equals the flag under op 6 (BR_TRUE), equals the inverted flag under op 7 (BR_FALSE), and is 0 under every other op.
- R9: No op other than MOVE_IN changes any register.
- R10: NaN and infinity patterns are ordered as plain sign-magnitude integers. For example, 0x7FC00000 compares greater than 0x7F800000.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | rising-edge clock |
| rst_n | input | 1 | active-low asynchronous reset |
| op_i | input | 3 | operation code |
| fs_i | input | 5 | first register index (write target, move-out source, left compare operand) |
| ft_i | input | 5 | second register index (right compare operand) |
| wdata_i | input | 32 | word from the integer side for MOVE_IN |
| rdata_o | output | 32 | word to the integer side under MOVE_OUT |
| cc_flag_o | output | 1 | condition flag |
| br_taken_o | output | 1 | branch decision under BR_TRUE and BR_FALSE |

## Verification
The bench works through the signed-zero corners: +0 against -0 must be equal and not less-than, in both orders. A design that compared raw bits would call them unequal, and would call one of them smaller. Pairs of negative numbers catch a design that forgot to reverse the magnitude order. Mixed-sign pairs and NaN or infinity patterns catch a design that compared the words as two's-complement values, or that special-cased NaN. Idle, move and branch operations are interleaved between compares so that a flag that drifts on non-compare codes shows up at the branch output. MOVE_OUT reads after random writes catch a register that is written under the wrong code or at the wrong index.

// File: rtl/fpc_pkg.sv
package fpc_pkg;

    typedef enum logic [2:0] {
        OP_IDLE     = 3'd0,
        OP_MOVE_IN  = 3'd1,
        OP_MOVE_OUT = 3'd2,
        OP_CMP_EQ   = 3'd3,
        OP_CMP_LE   = 3'd4,
        OP_CMP_LT   = 3'd5,
        OP_BR_TRUE  = 3'd6,
        OP_BR_FALSE = 3'd7
    } fpc_op_e;

    typedef enum logic {
        CC_CLEAR = 1'b0,
        CC_SET   = 1'b1
    } cc_state_e;

endpackage

// File: rtl/fpc_regfile.sv
module fpc_regfile #(
    parameter int NREG  = 32,
    parameter int W     = 32,
    parameter int IDX_W = $clog2(NREG)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic [IDX_W-1:0] waddr,
    input  logic [W-1:0]     wdata,
    input  logic [IDX_W-1:0] raddr_a,
    input  logic [IDX_W-1:0] raddr_b,
    output logic [W-1:0]     rdata_a,
    output logic [W-1:0]     rdata_b
);

    logic [W-1:0] bank [NREG];

    for (genvar g = 0; g < NREG; g++) begin : g_word
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                bank[g] <= '0;
            else if (we && (waddr == IDX_W'(g)))
                bank[g] <= wdata;
        end
    end

    assign rdata_a = bank[raddr_a];
    assign rdata_b = bank[raddr_b];

endmodule

// File: rtl/fpc_compare.sv
module fpc_compare #(
    parameter int W = 32
) (
    input  logic [W-1:0] lhs,
    input  logic [W-1:0] rhs,
    output logic         is_eq,
    output logic         is_lt
);

    localparam int MAG_W = W - 1;

    logic             s_l, s_r;
    logic [MAG_W-1:0] m_l, m_r;
    logic             both_zero;

    always_comb begin
        s_l       = lhs[W-1];
        s_r       = rhs[W-1];
        m_l       = lhs[MAG_W-1:0];
        m_r       = rhs[MAG_W-1:0];
        both_zero = (m_l == '0) && (m_r == '0);
        is_eq     = both_zero || (lhs == rhs);
        if (both_zero)
            is_lt = 1'b0;
        else if (s_l != s_r)
            is_lt = s_l;
        else if (s_l)
            is_lt = m_l > m_r;
        else
            is_lt = m_l < m_r;
    end

endmodule

// File: rtl/fpc_unit.sv
module fpc_unit
    import fpc_pkg::*;
#(
    parameter int NREG  = 32,
    parameter int W     = 32,
    parameter int IDX_W = $clog2(NREG)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [2:0]       op_i,
    input  logic [IDX_W-1:0] fs_i,
    input  logic [IDX_W-1:0] ft_i,
    input  logic [W-1:0]     wdata_i,
    output logic [W-1:0]     rdata_o,
    output logic             cc_flag_o,
    output logic             br_taken_o
);

    fpc_op_e   op;
    cc_state_e cc_q, cc_d;
    logic      wr_en;
    logic [W-1:0] word_a, word_b;
    logic      cmp_eq, cmp_lt;

    assign op = fpc_op_e'(op_i);

    fpc_regfile #(.NREG(NREG), .W(W), .IDX_W(IDX_W)) u_bank (
        .clk     (clk),
        .rst_n   (rst_n),
        .we      (wr_en),
        .waddr   (fs_i),
        .wdata   (wdata_i),
        .raddr_a (fs_i),
        .raddr_b (ft_i),
        .rdata_a (word_a),
        .rdata_b (word_b)
    );

    fpc_compare #(.W(W)) u_cmp (
        .lhs   (word_a),
        .rhs   (word_b),
        .is_eq (cmp_eq),
        .is_lt (cmp_lt)
    );

    // flag state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cc_q <= CC_CLEAR;
        else
            cc_q <= cc_d;
    end

    // next state and outputs
    always_comb begin
        cc_d       = cc_q;
        wr_en      = 1'b0;
        rdata_o    = '0;
        br_taken_o = 1'b0;
        unique case (op)
            OP_IDLE:     ;
            OP_MOVE_IN:  wr_en = 1'b1;
            OP_MOVE_OUT: rdata_o = word_a;
            OP_CMP_EQ:   cc_d = cmp_eq ? CC_SET : CC_CLEAR;
            OP_CMP_LE:   cc_d = (cmp_eq || cmp_lt) ? CC_SET : CC_CLEAR;
            OP_CMP_LT:   cc_d = cmp_lt ? CC_SET : CC_CLEAR;
            OP_BR_TRUE:  br_taken_o = (cc_q == CC_SET);
            OP_BR_FALSE: br_taken_o = (cc_q == CC_CLEAR);
            default:     ;
        endcase
    end

    assign cc_flag_o = (cc_q == CC_SET);

endmodule

// File: rtl/fpc_unit_chk.sv
module fpc_unit_chk #(
    parameter int W     = 32,
    parameter int IDX_W = 5
) (
    input logic             clk,
    input logic             rst_n,
    input logic [2:0]       op_i,
    input logic [IDX_W-1:0] fs_i,
    input logic [IDX_W-1:0] ft_i,
    input logic [W-1:0]     rdata_o,
    input logic             cc_flag_o,
    input logic             br_taken_o
);

    AST_FLAG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i < 3'd3 || op_i > 3'd5) |=> $stable(cc_flag_o)); // R7

    AST_BR_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i < 3'd6) |-> !br_taken_o); // R8

    AST_BR_TRUE: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i == 3'd6) |-> (br_taken_o == cc_flag_o)); // R8

    AST_BR_FALSE: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i == 3'd7) |-> (br_taken_o != cc_flag_o)); // R8

    AST_RDATA_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i != 3'd2) |-> (rdata_o == '0)); // R3

    AST_EQ_SELF: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i == 3'd3 && fs_i == ft_i) |=> cc_flag_o); // R4

    AST_LT_SELF: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i == 3'd5 && fs_i == ft_i) |=> !cc_flag_o); // R5

    AST_LE_SELF: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i == 3'd4 && fs_i == ft_i) |=> cc_flag_o); // R6

endmodule

bind fpc_unit fpc_unit_chk #(.W(W), .IDX_W(IDX_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .op_i       (op_i),
    .fs_i       (fs_i),
    .ft_i       (ft_i),
    .rdata_o    (rdata_o),
    .cc_flag_o  (cc_flag_o),
    .br_taken_o (br_taken_o)
);

// File: tb/fpc_unit_test.sv
module fpc_unit_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  op_i = '0;
    logic [4:0]  fs_i = '0;
    logic [4:0]  ft_i = '0;
    logic [31:0] wdata_i = '0;
    logic [31:0] rdata_o;
    logic        cc_flag_o;
    logic        br_taken_o;

    int checks = 0;
    int failures = 0;
    logic [31:0] model [32];
    logic        mflag = 1'b0;

    always #5 clk = ~clk;

    fpc_unit uut (.*);

    // ordering key: sign-magnitude word mapped to a signed integer
    function automatic longint key(input logic [31:0] v);
        longint m = longint'(v[30:0]);
        return v[31] ? -m : m;
    endfunction

    function automatic string rq(input logic [2:0] op);
        case (op)
            3'd3: return "R4";
            3'd4: return "R6";
            3'd5: return "R5";
            default: return "R7";
        endcase
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic step(input logic [2:0] op, input logic [4:0] fs, input logic [4:0] ft,
                        input logic [31:0] wd, input string tag);
        logic nf;
        @(negedge clk);
        op_i = op; fs_i = fs; ft_i = ft; wdata_i = wd;
        #1;
        chk((op == 3'd2) ? "R3 MOVE_OUT" : "R3 quiet", rdata_o,
            (op == 3'd2) ? model[fs] : 32'h0);
        chk("R8 branch", {31'h0, br_taken_o},
            {31'h0, (op == 3'd6) ? mflag : (op == 3'd7) ? !mflag : 1'b0});
        nf = mflag;
        case (op)
            3'd3: nf = key(model[fs]) == key(model[ft]);
            3'd4: nf = key(model[fs]) <= key(model[ft]);
            3'd5: nf = key(model[fs]) <  key(model[ft]);
            default: ;
        endcase
        @(posedge clk);
        if (op == 3'd1) model[fs] = wd;
        mflag = nf;
        #1;
        chk({rq(op), " ", tag}, {31'h0, cc_flag_o}, {31'h0, mflag});
    endtask

    task automatic put(input logic [4:0] r, input logic [31:0] v);
        step(3'd1, r, 5'd0, v, "R2 write");
    endtask

    task automatic cmp3(input logic [4:0] a, input logic [4:0] b, input string tag);
        step(3'd3, a, b, '0, tag);
        step(3'd4, a, b, '0, tag);
        step(3'd5, a, b, '0, tag);
    endtask

    function automatic logic [31:0] pick();
        case ($urandom % 8)
            0: return 32'h0000_0000;
            1: return 32'h8000_0000;
            2: return 32'h7F80_0000;
            3: return 32'h7FC0_0000;
            4: return {1'b1, 31'($urandom % 4)};
            5: return {1'b0, 31'($urandom % 4)};
            default: return $urandom;
        endcase
    endfunction

    initial begin
        #(200000 * 10);
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        void'($urandom(32'd1357));
        for (int i = 0; i < 32; i++) model[i] = '0;
        #23 rst_n = 1'b1;
        #1;
        chk("R1 flag", {31'h0, cc_flag_o}, 32'h0);
        step(3'd2, 5'd17, 5'd0, '0, "R1 reg zero");

        put(5'd1, 32'h0000_0000);
        put(5'd2, 32'h8000_0000);
        cmp3(5'd1, 5'd2, "+0 vs -0");
        cmp3(5'd2, 5'd1, "-0 vs +0");
        put(5'd3, 32'hC000_0000);
        put(5'd4, 32'hBF80_0000);
        cmp3(5'd3, 5'd4, "neg pair");
        cmp3(5'd4, 5'd3, "neg pair rev");
        put(5'd5, 32'h3F80_0000);
        cmp3(5'd4, 5'd5, "mixed sign");
        cmp3(5'd2, 5'd4, "-0 vs neg");
        put(5'd6, 32'h7FC0_0000);
        put(5'd7, 32'h7F80_0000);
        cmp3(5'd7, 5'd6, "R10 inf vs nan");
        cmp3(5'd6, 5'd7, "R10 nan vs inf");
        step(3'd6, 5'd0, 5'd0, 32'hFFFF_FFFF, "R9 branch");
        step(3'd7, 5'd0, 5'd0, 32'hFFFF_FFFF, "R9 branch");
        step(3'd2, 5'd6, 5'd0, '0, "R2 readback");
        step(3'd0, 5'd6, 5'd6, 32'h1234_5678, "idle");
        step(3'd2, 5'd6, 5'd0, '0, "R9 after idle");

        for (int n = 0; n < 1500; n++) begin
            logic [2:0] op = 3'($urandom % 8);
            step(op, 5'($urandom % 8), 5'($urandom % 8),
                 (op == 3'd1) ? pick() : $urandom, "random");
        end

        for (int i = 0; i < 32; i++) step(3'd2, 5'(i), 5'd0, '0, "R2 R9 final");

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule